// File: doc/BRIEF.md
# Strided 2D Window Address Generator

This block produces the address stream for a sequential port that walks a two-dimensional window of memory. A start pulse loads a port address. Each step strobe then consumes the current address and moves on. Steps advance one word at a time along a row. After the last word of a row, a programmable skip is added, and the next row begins. Once the programmed number of rows has been walked, the block raises ready. It then accepts no more accesses until it receives a new start.

The port may be confined to a power-of-two region that is smaller than the physical memory. Port address arithmetic wraps inside that region. Because of the wrap, a large skip acts as a negative stride, so rows can be read bottom-up. A skip equal to the row length visits every other row, which splits interleaved fields. The region's placement comes from a base input, which forms the upper bits of the physical address.

The window geometry (row length, row count, skip) can be fixed by parameters. Alternatively, it can be sampled from inputs at each start. In that case an illegal geometry is refused and reported.

Top module: `win_addr_gen`

## Requirements
- R1: When `start` is high at a clock edge, the port address takes `start_addr`, the row and word counters clear, and `ready` goes low (if the geometry is legal). `start` wins over `step` in the same cycle.
- R2: A step accepted while `ready` is low (and `start` is low) advances the port address by one, unless it is the last word of a row.
- R3: On the step that completes a row of `row_len` words, the next port address is the last word's address + 1 + skip.
- R4: The step that completes row number `rows` sets `ready` high on that edge. While `ready` is high and no start arrives, `ready` and the address hold.
- R5: A step while `ready` is high (including after reset, before any start) leaves the address unchanged, and `err` is high for exactly the following cycle.
- R6: All port address arithmetic wraps modulo 2^PORT_AW. A skip of 2^PORT_AW − 2·row_len therefore steps back by one row.
- R7: `phys_addr` is `base` placed above the PORT_AW-bit port address. It follows `base` combinationally at any time.
- R8: With dynamic geometry, `row_len`, `rows` and `skip` are sampled only at start. Changing them during a window has no effect on it.
- R9: With dynamic geometry, a start whose geometry is illegal sets `ready` high and pulses `err` for one cycle. Illegal means any of: row_len not a multiple of RATIO, row_len < 4·RATIO, skip zero, skip not a multiple of RATIO, or rows zero.
- R10: After reset the port address is 0, `ready` is 1 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load start address and begin a window |
| start_addr | input | PORT_AW | Port address of the first word |
| base | input | MEM_AW-PORT_AW | Region select, upper physical address bits |
| step | input | 1 | Consume the current address |
| row_len | input | CNT_W | Words per row (dynamic mode) |
| rows | input | CNT_W | Rows per window (dynamic mode) |
| skip | input | PORT_AW | Gap added after each row (dynamic mode) |
| phys_addr | output | MEM_AW | Physical address of the current access |
| ready | output | 1 | Window finished or idle |
| err | output | 1 | One-cycle pulse: stray step or rejected geometry |

## Verification
The bench builds the block with an 8-bit memory address, a 6-bit port address, RATIO of 2, 8-bit counters and dynamic geometry. A 64-word port space lets wrap-around, backward strides and alternate-row skips appear within a few dozen steps. The 2-bit base exercises region placement. An even ratio makes the odd-length and odd-skip rejections reachable alongside the short-row rule.

// File: rtl/wag_pkg.sv
package wag_pkg;
  // Legal window geometry for a port with `ratio` port words per memory word.
  function automatic logic cfg_legal(input logic [31:0] len, input logic [31:0] nrows,
                                     input logic [31:0] gap, input int unsigned ratio);
    return ((len % ratio) == 0) && (len >= 4 * ratio) && (gap != 0) &&
           ((gap % ratio) == 0) && (nrows != 0);
  endfunction
endpackage

// File: rtl/wag_cfg.sv
module wag_cfg #(
  parameter int CNT_W = 16,
  parameter int PORT_AW = 20,
  parameter int unsigned RATIO = 2,
  parameter bit DYNAMIC = 1'b1,
  parameter int FIX_LEN = 16,
  parameter int FIX_ROWS = 4,
  parameter int FIX_SKIP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   in_len,
  input  logic [CNT_W-1:0]   in_rows,
  input  logic [PORT_AW-1:0] in_skip,
  output logic [CNT_W-1:0]   len_q,
  output logic [CNT_W-1:0]   rows_q,
  output logic [PORT_AW-1:0] skip_q,
  output logic               cfg_bad
);
  generate
    if (DYNAMIC) begin : g_dyn
      logic [CNT_W-1:0]   len_r, rows_r;
      logic [PORT_AW-1:0] skip_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          len_r  <= CNT_W'(FIX_LEN);
          rows_r <= CNT_W'(FIX_ROWS);
          skip_r <= PORT_AW'(FIX_SKIP);
        end else if (start) begin
          len_r  <= in_len;
          rows_r <= in_rows;
          skip_r <= in_skip;
        end
      end
      assign len_q   = len_r;
      assign rows_q  = rows_r;
      assign skip_q  = skip_r;
      assign cfg_bad = !wag_pkg::cfg_legal(32'(in_len), 32'(in_rows), 32'(in_skip), RATIO);
    end else begin : g_fix
      assign len_q   = CNT_W'(FIX_LEN);
      assign rows_q  = CNT_W'(FIX_ROWS);
      assign skip_q  = PORT_AW'(FIX_SKIP);
      assign cfg_bad = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wag_count.sv
module wag_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] rows,
  output logic             row_end,
  output logic             win_end
);
  logic [CNT_W-1:0] col, row;

  assign row_end = (col == len - 1'b1);
  assign win_end = row_end && (row == rows - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (start) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (row_end) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wag_addr.sv
module wag_addr #(
  parameter int PORT_AW = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PORT_AW-1:0] load_addr,
  input  logic               adv,
  input  logic               jump,
  input  logic [PORT_AW-1:0] skip,
  output logic [PORT_AW-1:0] addr
);
  // Next port address; wraps naturally at PORT_AW bits.
  function automatic logic [PORT_AW-1:0] advance(input logic [PORT_AW-1:0] a,
                                                 input logic j,
                                                 input logic [PORT_AW-1:0] gap);
    return j ? (a + 1'b1 + gap) : (a + 1'b1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (adv)  addr <= advance(addr, jump, skip);
  end
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen #(
  parameter int MEM_AW = 22,
  parameter int PORT_AW = 20,
  parameter int unsigned RATIO = 2,
  parameter int CNT_W = 16,
  parameter bit DYNAMIC = 1'b1,
  parameter int FIX_LEN = 16,
  parameter int FIX_ROWS = 4,
  parameter int FIX_SKIP = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [PORT_AW-1:0]        start_addr,
  input  logic [MEM_AW-PORT_AW-1:0] base,
  input  logic                      step,
  input  logic [CNT_W-1:0]          row_len,
  input  logic [CNT_W-1:0]          rows,
  input  logic [PORT_AW-1:0]        skip,
  output logic [MEM_AW-1:0]         phys_addr,
  output logic                      ready,
  output logic                      err
);
  localparam int BASE_W = MEM_AW - PORT_AW;

  logic [CNT_W-1:0]   len_q, rows_q;
  logic [PORT_AW-1:0] skip_q, port_addr;
  logic cfg_bad, row_end, win_end;
  logic acc_fire, stray_step;

  assign acc_fire   = step && !ready && !start;
  assign stray_step = step && ready && !start;

  wag_cfg #(
    .CNT_W(CNT_W), .PORT_AW(PORT_AW), .RATIO(RATIO), .DYNAMIC(DYNAMIC),
    .FIX_LEN(FIX_LEN), .FIX_ROWS(FIX_ROWS), .FIX_SKIP(FIX_SKIP)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_len(row_len), .in_rows(rows), .in_skip(skip),
    .len_q(len_q), .rows_q(rows_q), .skip_q(skip_q), .cfg_bad(cfg_bad)
  );

  wag_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(acc_fire),
    .len(len_q), .rows(rows_q), .row_end(row_end), .win_end(win_end)
  );

  wag_addr #(.PORT_AW(PORT_AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_addr(start_addr),
    .adv(acc_fire), .jump(row_end), .skip(skip_q), .addr(port_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      err   <= 1'b0;
    end else if (start) begin
      ready <= cfg_bad;
      err   <= cfg_bad;
    end else begin
      err <= stray_step;
      if (acc_fire && win_end) ready <= 1'b1;
    end
  end

  assign phys_addr = {BASE_W'(base), port_addr};
endmodule

// File: rtl/wag_checker.sv
module wag_checker #(
  parameter int PORT_AW = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               step,
  input logic [PORT_AW-1:0] start_addr,
  input logic [PORT_AW-1:0] port_addr,
  input logic               ready,
  input logic               err,
  input logic               acc_fire,
  input logic               row_end,
  input logic               win_end,
  input logic               cfg_bad
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> port_addr == $past(start_addr)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_bad) |=> !ready); // R1
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !row_end) |=> port_addr == PORT_AW'($past(port_addr) + 1'b1)); // R2
  AST_WIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && win_end) |=> ready); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && $stable(port_addr))); // R4
  AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && step && !start) |=> err); // R5
  AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_bad) |=> (ready && err)); // R9
endmodule

bind win_addr_gen wag_checker #(.PORT_AW(PORT_AW)) u_wag_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step), .start_addr(start_addr),
  .port_addr(port_addr), .ready(ready), .err(err), .acc_fire(acc_fire),
  .row_end(row_end), .win_end(win_end), .cfg_bad(cfg_bad)
);

// File: tb/win_addr_gen_bench.sv
`timescale 1ns/1ps
module win_addr_gen_bench;
  localparam int MAW = 8, PAW = 6, CW = 8, RT = 2;
  localparam int SPACE = 1 << PAW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, step = 1'b0;
  logic [PAW-1:0] start_addr = '0, skip = '0;
  logic [MAW-PAW-1:0] base = '0;
  logic [CW-1:0] row_len = '0, rows = '0;
  logic [MAW-1:0] phys_addr;
  logic ready, err;

  int compared = 0, mismatched = 0;
  int m_a = 0, m_col = 0, m_row = 0, m_len = 16, m_rows = 4, m_skip = 16;
  bit m_ready = 1'b1, m_err = 1'b0;

  always #2.5 clk = ~clk;

  win_addr_gen #(.MEM_AW(MAW), .PORT_AW(PAW), .RATIO(RT), .CNT_W(CW), .DYNAMIC(1'b1))
  u_win_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .base(base),
    .step(step), .row_len(row_len), .rows(rows), .skip(skip),
    .phys_addr(phys_addr), .ready(ready), .err(err)
  );

  function automatic bit legal(int l, int r, int s);
    return (l % RT == 0) && (l >= 4 * RT) && (s > 0) && (s % RT == 0) && (r > 0);
  endfunction

  function automatic int exp_phys();
    return (int'(base) * SPACE) + m_a;
  endfunction

  task automatic check(input string tag);
    compared++;
    if (phys_addr !== MAW'(exp_phys()) || ready !== m_ready || err !== m_err) begin
      mismatched++;
      $display("FAIL %s: addr=%0d ready=%0b err=%0b expected addr=%0d ready=%0b err=%0b",
               tag, phys_addr, ready, err, exp_phys(), m_ready, m_err);
    end
  endtask

  // One clock with the given controls; the model follows the same edge.
  task automatic cyc(input bit st, input bit sp, input string tag, input string jump_tag);
    string t;
    t = tag;
    start = st; step = sp;
    @(posedge clk);
    if (st) begin
      m_a = int'(start_addr); m_col = 0; m_row = 0;
      m_len = int'(row_len); m_rows = int'(rows); m_skip = int'(skip);
      m_ready = !legal(m_len, m_rows, m_skip);
      m_err = m_ready;
    end else if (sp && m_ready) begin
      m_err = 1'b1;
    end else if (sp) begin
      m_err = 1'b0;
      m_col++;
      if (m_col == m_len) begin
        m_col = 0;
        m_a = (m_a + 1 + m_skip) % SPACE;
        m_row++;
        t = jump_tag;
        if (m_row == m_rows) begin m_ready = 1'b1; t = "R4"; end
      end else begin
        m_a = (m_a + 1) % SPACE;
      end
    end else begin
      m_err = 1'b0;
    end
    #1;
    start = 1'b0; step = 1'b0;
    check(t);
  endtask

  task automatic set_cfg(input int sa, input int l, input int r, input int s);
    start_addr = PAW'(sa); row_len = CW'(l); rows = CW'(r); skip = PAW'(s);
  endtask

  task automatic run_window(input int sa, input int l, input int r, input int s,
                            input string jtag, input bit rnd);
    set_cfg(sa, l, r, s);
    cyc(1'b1, 1'b0, "R1", "R1");
    if (rnd) begin  // R8: disturb geometry inputs during the window
      row_len = CW'($urandom_range(255)); rows = CW'($urandom_range(255));
      skip = PAW'($urandom_range(63));
    end
    while (!m_ready) begin
      if (rnd && ($urandom_range(3) == 0)) cyc(1'b0, 1'b0, "R8", "R8");
      if (rnd && ($urandom_range(5) == 0)) base = 2'($urandom_range(3));  // R7
      cyc(1'b0, 1'b1, rnd ? "R8" : "R2", jtag);
    end
    cyc(1'b0, 1'b1, "R5", "R5");
    cyc(1'b0, 1'b0, "R5", "R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1; check("R10");
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, "R10", "R10");
    cyc(1'b0, 1'b1, "R5", "R5");                 // step before any start
    cyc(1'b0, 1'b0, "R5", "R5");
    run_window(10, 8, 3, 4, "R3", 1'b0);
    run_window(40, 8, 4, SPACE - 16, "R6", 1'b0); // backward one row per row
    run_window(0, 8, 3, 8, "R3", 1'b0);           // alternate rows
    run_window(60, 8, 2, 2, "R6", 1'b0);          // wraps past top of space
    base = 2'd3; cyc(1'b0, 1'b0, "R7", "R7");
    base = 2'd1; cyc(1'b0, 1'b0, "R7", "R7");
    // R1: restart in the middle of a window, start wins over step
    set_cfg(20, 10, 2, 6);
    cyc(1'b1, 1'b0, "R1", "R1");
    cyc(1'b0, 1'b1, "R2", "R3");
    cyc(1'b0, 1'b1, "R2", "R3");
    set_cfg(33, 8, 1, 2);
    cyc(1'b1, 1'b1, "R1", "R1");
    cyc(1'b0, 1'b1, "R2", "R3");
    // R9: illegal geometries
    set_cfg(5, 6, 2, 2);  cyc(1'b1, 1'b0, "R9", "R9"); cyc(1'b0, 1'b1, "R9", "R9");
    set_cfg(5, 9, 2, 2);  cyc(1'b1, 1'b0, "R9", "R9");
    set_cfg(5, 8, 2, 0);  cyc(1'b1, 1'b0, "R9", "R9");
    set_cfg(5, 8, 2, 3);  cyc(1'b1, 1'b0, "R9", "R9");
    set_cfg(5, 8, 0, 2);  cyc(1'b1, 1'b0, "R9", "R9"); cyc(1'b0, 1'b0, "R9", "R9");
    for (int i = 0; i < 30; i++) begin
      base = 2'($urandom_range(3));
      run_window($urandom_range(63), 2 * (4 + $urandom_range(4)), 1 + $urandom_range(3),
                 2 * (1 + $urandom_range(30)), "R3", 1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule